// File: doc/BRIEF.md
# Class-Selected Performance Event Counter

This block is one hardware performance counter. It is 64 bits wide and advances on events picked by a selector register. The selector holds a class code and an event mask. The class code names one group of raw event strobes. The mask names which strobes in that group count.

Every cycle the block receives one flat vector of strobes. It is laid out as six groups of twenty. The counter advances by one when at least one enabled strobe of the selected group is high. This holds no matter how many of them fire together. A selector that is not well formed stops all counting. That means an unknown class code, or a mask bit the class does not define.

Software reaches the selector and the counter through plain write-enable/data ports and reads both back directly. A write to the counter in the same cycle as an event wins over the increment. A selector write governs the events from the next cycle on.

Top module: `pmc_event_counter`

## Requirements
- R1: While reset is high, at each clock edge both the selector readback and the counter clear to zero.
- R2: The selector word holds the class code in bits 4:1 and the event mask in bits 24:5. A write stores exactly those bits. Bit 0 and bits 31:25 always read as zero.
- R3: The mask bits defined for each class code are as follows:
  - code 0: bits 5..24
  - codes 1 and 2: bits 5..10
  - code 3: bits 6..8
  - code 4: bits 5 and 6
  - code 5: bits 5, 7, 9, 11, 13 and 15
- R4: The strobe for class c and mask bit b sits at index c*20 + (b-5) of the strobe vector. With a well-formed selector, the counter rises by one at a clock edge when any enabled strobe of the selected class is high. Strobes of other classes have no effect.
- R5: Any number of enabled strobes high in the same cycle raises the counter by exactly one.
- R6: A class code of 6 to 15 stops the counter from advancing.
- R7: If any set mask bit is not defined for the selected class, the counter does not advance, even when defined bits are also set.
- R8: A mask of all zeros means no event, and the counter holds.
- R9: A counter write loads the written value and takes priority over an increment in the same cycle.
- R10: The counter wraps from all ones to zero on an increment.
- R11: A selector write takes effect for strobes from the following cycle on. Strobes in the write cycle are judged against the old selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Selector write enable |
| sel_wdata | input | 32 | Selector write data |
| sel_rdata | output | 32 | Selector readback |
| cnt_we | input | 1 | Counter write enable |
| cnt_wdata | input | 64 | Counter write data |
| cnt_rdata | output | 64 | Counter value |
| evt_strobe | input | 120 | Raw event strobes, six classes of twenty |

## Verification
The assertions check the cycle-level rules on every cycle:
- the counter moves by at most one per cycle;
- a write wins over an increment;
- the counter holds under an unknown class, an undefined mask bit or an empty mask;
- selector readback keeps only its legal fields.

Only the bench scenarios can show that the correct strobe group and bits are chosen for each class. The same is true of the one-cycle delay of a selector write, and of the wrap from all ones to zero under a live event. The bench compares each cycle against a reference model driven by random selectors and sparse strobes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int CLS_W    = 4;
    localparam int MASK_W   = 20;
    localparam int MASK_LSB = 5;
    localparam int NUM_CLS  = 6;
    localparam int SEL_W    = 32;
    localparam int CNT_W    = 64;
    localparam int EVT_W    = NUM_CLS * MASK_W;
    localparam int SEL_TOP  = MASK_LSB + MASK_W - 1;

    typedef enum logic [CLS_W-1:0] {
        CLS_RETIRE = 4'd0,
        CLS_FLOW   = 4'd1,
        CLS_CACHE  = 4'd2,
        CLS_STALL  = 4'd3,
        CLS_MISC   = 4'd4,
        CLS_LAT    = 4'd5
    } cls_e;

    // Selector fields, upper field first so the struct maps onto bits SEL_TOP:1
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [CLS_W-1:0]  cls;
    } sel_t;

    // Writable bits of the selector word
    localparam logic [SEL_W-1:0] SEL_WR_MASK =
        {{(SEL_W-SEL_TOP-1){1'b0}}, {(SEL_TOP){1'b1}}, 1'b0};

    // Mask bits that a class defines; index 0 corresponds to selector bit MASK_LSB
    function automatic logic [MASK_W-1:0] legal_mask(input logic [CLS_W-1:0] c);
        logic [MASK_W-1:0] m;
        m = '0;
        case (c)
            CLS_RETIRE: m = '1;
            CLS_FLOW,
            CLS_CACHE:  for (int i = 0; i < 6; i++) m[i] = 1'b1;
            CLS_STALL:  for (int i = 1; i < 4; i++) m[i] = 1'b1;
            CLS_MISC:   for (int i = 0; i < 2; i++) m[i] = 1'b1;
            CLS_LAT:    for (int i = 0; i < 11; i += 2) m[i] = 1'b1;
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pmc_sel_reg.sv
module pmc_sel_reg
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wdata,
    output sel_t             sel,
    output logic [SEL_W-1:0] rdata
);

    logic [SEL_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (we)
            word_q <= wdata & SEL_WR_MASK;
    end

    assign sel   = sel_t'(word_q[SEL_TOP:1]);
    assign rdata = word_q;

    // R1
    sel_reset_chk: assert property (@(posedge clk) rst |=> rdata == '0);

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata[SEL_TOP:1] == $past(wdata[SEL_TOP:1])) && !rdata[0]
               && (rdata[SEL_W-1:SEL_TOP+1] == '0));

endmodule

// File: rtl/pmc_event_match.sv
module pmc_event_match
    import pmc_pkg::*;
(
    input  sel_t             sel,
    input  logic [EVT_W-1:0] evt,
    output logic             hit
);

    logic [MASK_W-1:0] grp [NUM_CLS];
    logic [MASK_W-1:0] sel_grp;
    logic [MASK_W-1:0] bad_bits;
    logic              cls_ok;

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_grp
        assign grp[g] = evt[g*MASK_W +: MASK_W];
    end

    always_comb begin
        sel_grp = '0;
        for (int i = 0; i < NUM_CLS; i++)
            if (sel.cls == CLS_W'(i))
                sel_grp = grp[i];
    end

    assign cls_ok   = sel.cls < CLS_W'(NUM_CLS);
    assign bad_bits = sel.mask & ~legal_mask(sel.cls);
    assign hit      = cls_ok && (bad_bits == '0) && |(sel.mask & sel_grp);

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata;
        else if (inc)
            q <= q + W'(1);
    end

    // R1
    cnt_reset_chk: assert property (@(posedge clk) rst |=> q == '0);

    // R9
    cnt_wr_priority_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> q == $past(wdata));

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !we) |=> q == $past(q) + W'(1));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !we) |=> $stable(q));

endmodule

// File: rtl/pmc_event_counter.sv
module pmc_event_counter
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_rdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic [EVT_W-1:0] evt_strobe
);

    sel_t sel;
    logic hit;

    pmc_sel_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .we    (sel_we),
        .wdata (sel_wdata),
        .sel   (sel),
        .rdata (sel_rdata)
    );

    pmc_event_match u_match (
        .sel (sel),
        .evt (evt_strobe),
        .hit (hit)
    );

    pmc_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (hit),
        .we    (cnt_we),
        .wdata (cnt_wdata),
        .q     (cnt_rdata)
    );

    // R6
    undef_class_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_rdata[4:1] >= CLS_W'(NUM_CLS) && !cnt_we) |=> $stable(cnt_rdata));

    // R7
    undef_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel_rdata[SEL_TOP:MASK_LSB] & ~legal_mask(sel_rdata[4:1])) != '0 && !cnt_we)
        |=> $stable(cnt_rdata));

    // R8
    no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_rdata[SEL_TOP:MASK_LSB] == '0 && !cnt_we) |=> $stable(cnt_rdata));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> (cnt_rdata - $past(cnt_rdata)) <= CNT_W'(1));

endmodule

// File: tb/pmc_event_counter_tb.sv
module pmc_event_counter_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_we = 1'b0;
    logic [31:0]  sel_wdata = '0;
    logic [31:0]  sel_rdata;
    logic         cnt_we = 1'b0;
    logic [63:0]  cnt_wdata = '0;
    logic [63:0]  cnt_rdata;
    logic [119:0] evt_strobe = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_sel = '0;
    logic [63:0] m_cnt = '0;

    always #5 clk = ~clk;

    pmc_event_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .sel_rdata  (sel_rdata),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .cnt_rdata  (cnt_rdata),
        .evt_strobe (evt_strobe)
    );

    // Defined mask bits per class (R3), index 0 = selector bit 5
    function automatic logic [19:0] def_mask(input logic [3:0] c);
        case (c)
            4'd0:       return 20'hFFFFF;
            4'd1, 4'd2: return 20'h0003F;
            4'd3:       return 20'h0000E;
            4'd4:       return 20'h00003;
            4'd5:       return 20'h00555;
            default:    return 20'h00000;
        endcase
    endfunction

    function automatic bit exp_hit(input logic [31:0] s, input logic [119:0] ev);
        logic [3:0]  c;
        logic [19:0] m;
        c = s[4:1];
        m = s[24:5];
        if (c > 4'd5) return 1'b0;
        if ((m & ~def_mask(c)) != 0) return 1'b0;
        return |(m & ev[c*20 +: 20]);
    endfunction

    function automatic logic [119:0] ev1(input int c, input int b);
        logic [119:0] v;
        v = '0;
        v[c*20 + b - 5] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] mk_sel(input int c, input logic [19:0] m);
        return {7'b0, m, 4'(c), 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic swe, input logic [31:0] swd, input logic cwe,
                       input logic [63:0] cwd, input logic [119:0] ev, input string tag);
        sel_we     = swe;
        sel_wdata  = swd;
        cnt_we     = cwe;
        cnt_wdata  = cwd;
        evt_strobe = ev;
        @(posedge clk);
        if (cwe) m_cnt = cwd;
        else if (exp_hit(m_sel, ev)) m_cnt = m_cnt + 64'd1;
        if (swe) m_sel = swd & 32'h01FF_FFFE;
        @(negedge clk);
        chk({tag, " selector"}, {32'b0, sel_rdata}, {32'b0, m_sel});
        chk({tag, " counter"}, cnt_rdata, m_cnt);
    endtask

    function automatic logic [31:0] rand_sel();
        int r;
        int c;
        r = int'($urandom % 10);
        c = int'($urandom % 6);
        if (r < 7)       return mk_sel(c, 20'($urandom) & def_mask(4'(c))) | ($urandom & 32'hFE00_0001);
        else if (r == 7) return mk_sel(6 + int'($urandom % 10), 20'($urandom));
        else if (r == 8) return mk_sel(1 + int'($urandom % 5), def_mask(4'(1 + c % 5)) | 20'h80000);
        else             return mk_sel(c, 20'h0);
    endfunction

    function automatic logic [119:0] rand_ev();
        logic [127:0] a, b;
        a = {$urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom};
        return a[119:0] & b[119:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 selector reset", {32'b0, sel_rdata}, 64'd0);
        chk("R1 counter reset", cnt_rdata, 64'd0);
        rst = 1'b0;

        // R2: only legal fields are stored
        cyc(1, 32'hFFFF_FFFF, 0, 0, '0, "R2 full write");
        chk("R2 readback", {32'b0, sel_rdata}, 64'h0000_0000_01FF_FFFE);

        // R8: empty mask with all strobes firing
        cyc(1, mk_sel(0, 20'h0), 0, 0, '0, "R8 setup");
        cyc(0, 0, 0, 0, '1, "R8 empty mask");
        chk("R8 held", cnt_rdata, 64'd0);

        // R3/R4: class 3 bit 7; a strobe in another class is ignored
        cyc(1, mk_sel(3, 20'h4), 0, 0, '0, "R3 setup");
        cyc(0, 0, 0, 0, ev1(3, 7), "R4 class3 bit7");
        chk("R4 counted", cnt_rdata, 64'd1);
        cyc(0, 0, 0, 0, ev1(2, 7) | ev1(0, 7), "R4 other class");
        chk("R4 other class ignored", cnt_rdata, 64'd1);

        // R5: every class-0 strobe at once
        cyc(1, mk_sel(0, 20'hFFFFF), 0, 0, '0, "R5 setup");
        cyc(0, 0, 0, 0, {100'b0, 20'hFFFFF}, "R5 many events");
        chk("R5 single step", cnt_rdata, 64'd2);

        // R6: undefined class
        cyc(1, mk_sel(9, 20'h1), 0, 0, '0, "R6 setup");
        cyc(0, 0, 0, 0, '1, "R6 undefined class");
        chk("R6 held", cnt_rdata, 64'd2);

        // R7: defined bit plus an undefined bit
        cyc(1, mk_sel(4, 20'h5), 0, 0, '0, "R7 setup");
        cyc(0, 0, 0, 0, ev1(4, 5), "R7 mixed mask");
        chk("R7 held", cnt_rdata, 64'd2);
        cyc(1, mk_sel(3, 20'h1), 0, 0, '0, "R7 setup b");
        cyc(0, 0, 0, 0, '1, "R7 class3 bit5");
        chk("R7 held b", cnt_rdata, 64'd2);

        // R3: class 5 odd-bit layout
        cyc(1, mk_sel(5, 20'h2), 0, 0, '0, "R3 setup b");
        cyc(0, 0, 0, 0, '1, "R3 class5 bit6");
        chk("R3 class5 bit6 undefined", cnt_rdata, 64'd2);
        cyc(1, mk_sel(5, 20'h4), 0, 0, '0, "R3 setup c");
        cyc(0, 0, 0, 0, ev1(5, 7), "R3 class5 bit7");
        chk("R3 class5 bit7 counted", cnt_rdata, 64'd3);

        // R9: write beats an increment
        cyc(0, 0, 1, 64'd100, ev1(5, 7), "R9 write priority");
        chk("R9 loaded", cnt_rdata, 64'd100);

        // R10: wrap
        cyc(0, 0, 1, '1, '0, "R10 load ones");
        cyc(0, 0, 0, 0, ev1(5, 7), "R10 wrap");
        chk("R10 wrapped", cnt_rdata, 64'd0);

        // R11: new selector applies from the next cycle
        cyc(1, mk_sel(0, 20'h1), 0, 0, '0, "R11 clear");
        cyc(1, mk_sel(1, 20'h1), 0, 0, ev1(1, 5), "R11 write cycle");
        chk("R11 old selector used", cnt_rdata, 64'd0);
        cyc(0, 0, 0, 0, ev1(1, 5), "R11 next cycle");
        chk("R11 new selector used", cnt_rdata, 64'd1);

        // Random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic        swe, cwe;
            logic [63:0] cwd;
            swe = ($urandom % 16) == 0;
            cwe = ($urandom % 64) == 0;
            cwd = ($urandom % 2) ? (64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16))
                                 : {$urandom, $urandom};
            cyc(swe, rand_sel(), cwe, cwd, rand_ev(), "R4 R6 R7 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule